// File: doc/BRIEF.md
# Packet-Reloaded Register File

This block holds the 32 general registers of a processing unit that runs one small program per packet. Each register is 32 bits wide. Two read ports return register contents in the same cycle as their addresses. One write port updates a register at the next rising clock edge. Register x0 is tied to zero.

Each packet starts with a one-cycle pulse on `sop_i`. At the clock edge that samples the pulse, the whole file is reloaded. Registers x6 to x14 take nine base-address words from the page-register bus, and every other register becomes zero. From the following cycle `ready_o` is high and the program may write. A write whose target is also being read in the same cycle is forwarded straight to the read port.

Top module: `pkt_regfile`

## Requirements
- R1: After reset every register reads zero on both read ports. Each read port returns the addressed register combinationally, and the two ports work independently, including when both address the same register.
- R2: Reading address 0 always returns zero. A write to address 0 changes nothing and is never forwarded.
- R3: `ready_o` is low from reset until the clock edge that samples `sop_i` high. It is high from the next cycle on, and a later `sop_i` keeps it high.
- R4: At a clock edge with `sop_i` high, register x(6+k) is loaded with the page word at bits [32k+31:32k] of `page_base_i`, for k = 0 to 8.
- R5: At a clock edge with `sop_i` high, every register outside x6 to x14 becomes zero, including registers written by the previous packet.
- R6: A write is accepted when `we_i` is high, `ready_o` is high and `sop_i` is low. The write takes effect at that clock edge, and the value is read from the next cycle until overwritten.
- R7: While an accepted write targets the register being read on a port, that port returns `wdata_i` in the same cycle.
- R8: While `sop_i` is high, or while `ready_o` is low, `we_i` has no effect. The register keeps its old value or its reload value, and nothing is forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sop_i | input | 1 | Start-of-packet pulse that triggers the reload |
| page_base_i | input | 288 | Nine 32-bit base-address words; word k goes to x(6+k) |
| we_i | input | 1 | Write request |
| waddr_i | input | 5 | Write register index |
| wdata_i | input | 32 | Write data |
| raddr_a_i | input | 5 | Read port A register index |
| rdata_a_o | output | 32 | Read port A data |
| raddr_b_i | input | 5 | Read port B register index |
| rdata_b_o | output | 32 | Read port B data |
| ready_o | output | 1 | High once the packet reload has completed |

## Verification
Read data is due in the same cycle as the read address. A forwarded write is also due in that cycle. A stored write, a reload and the rise of `ready_o` are all due one cycle after the edge that samples them. The bench changes inputs on the falling edge and samples the outputs one nanosecond later. Its reference model advances only at each rising edge, so every expectation for a cycle is computed from the state that was current before that edge.

// File: rtl/pkt_rf_pkg.sv
package pkt_rf_pkg;

    // Sequencer state: waiting for the first packet, or live.
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_LIVE = 1'b1
    } seq_state_e;

    // Number of read ports on the file.
    localparam int RF_RD_PORTS = 2;

endpackage

// File: rtl/rf_seq.sv
module rf_seq
    import pkt_rf_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sop_i,
    input  logic we_i,
    output logic ready_o,
    output logic init_o,
    output logic wr_ok_o
);

    typedef struct packed {
        seq_state_e state;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (sop_i) begin
            seq_d.state = SEQ_LIVE;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seq_q <= '{state: SEQ_IDLE};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign ready_o = (seq_q.state == SEQ_LIVE);
    assign init_o  = sop_i;
    assign wr_ok_o = we_i && ready_o && !sop_i;

endmodule

// File: rtl/rf_bank.sv
module rf_bank #(
    parameter int XLEN       = 32,
    parameter int NUM_REGS   = 32,
    parameter int INIT_FIRST = 6,
    parameter int INIT_COUNT = 9,
    localparam int AW        = $clog2(NUM_REGS),
    localparam int PAGE_W    = INIT_COUNT * XLEN
) (
    input  logic                               clk_i,
    input  logic                               rst_ni,
    input  logic                               init_i,
    input  logic [PAGE_W-1:0]                  page_base_i,
    input  logic                               wr_ok_i,
    input  logic [AW-1:0]                      waddr_i,
    input  logic [XLEN-1:0]                    wdata_i,
    output logic [NUM_REGS-1:0][XLEN-1:0]      regs_o
);

    typedef struct packed {
        logic [NUM_REGS-1:0][XLEN-1:0] regs;
    } bank_t;

    bank_t bank_d, bank_q;
    logic [NUM_REGS-1:0][XLEN-1:0] init_img;

    // Reload image: page words for the seeded window, zero elsewhere.
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_img
        if (g >= INIT_FIRST && g < INIT_FIRST + INIT_COUNT) begin : g_seed
            assign init_img[g] = page_base_i[(g - INIT_FIRST) * XLEN +: XLEN];
        end else begin : g_zero
            assign init_img[g] = '0;
        end
    end

    always_comb begin
        bank_d = bank_q;
        if (init_i) begin
            bank_d.regs = init_img;
        end else if (wr_ok_i && (waddr_i != '0)) begin
            bank_d.regs[waddr_i] = wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign regs_o = bank_q.regs;

endmodule

// File: rtl/rf_rdport.sv
module rf_rdport #(
    parameter int XLEN     = 32,
    parameter int NUM_REGS = 32,
    localparam int AW      = $clog2(NUM_REGS)
) (
    input  logic [NUM_REGS-1:0][XLEN-1:0] regs_i,
    input  logic [AW-1:0]                 raddr_i,
    input  logic                          fwd_en_i,
    input  logic [AW-1:0]                 waddr_i,
    input  logic [XLEN-1:0]               wdata_i,
    output logic [XLEN-1:0]               rdata_o
);

    logic hit;

    assign hit = fwd_en_i && (waddr_i == raddr_i);

    always_comb begin
        if (raddr_i == '0) begin
            rdata_o = '0;
        end else if (hit) begin
            rdata_o = wdata_i;
        end else begin
            rdata_o = regs_i[raddr_i];
        end
    end

endmodule

// File: rtl/pkt_regfile.sv
module pkt_regfile
    import pkt_rf_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int NUM_REGS   = 32,
    parameter int INIT_FIRST = 6,
    parameter int INIT_COUNT = 9,
    localparam int AW        = $clog2(NUM_REGS),
    localparam int PAGE_W    = INIT_COUNT * XLEN
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sop_i,
    input  logic [PAGE_W-1:0] page_base_i,
    input  logic              we_i,
    input  logic [AW-1:0]     waddr_i,
    input  logic [XLEN-1:0]   wdata_i,
    input  logic [AW-1:0]     raddr_a_i,
    output logic [XLEN-1:0]   rdata_a_o,
    input  logic [AW-1:0]     raddr_b_i,
    output logic [XLEN-1:0]   rdata_b_o,
    output logic              ready_o
);

    logic                          init;
    logic                          wr_ok;
    logic [NUM_REGS-1:0][XLEN-1:0] regs;
    logic [RF_RD_PORTS-1:0][AW-1:0]   rd_addr;
    logic [RF_RD_PORTS-1:0][XLEN-1:0] rd_data;

    rf_seq u_seq (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .sop_i   (sop_i),
        .we_i    (we_i),
        .ready_o (ready_o),
        .init_o  (init),
        .wr_ok_o (wr_ok)
    );

    rf_bank #(
        .XLEN       (XLEN),
        .NUM_REGS   (NUM_REGS),
        .INIT_FIRST (INIT_FIRST),
        .INIT_COUNT (INIT_COUNT)
    ) u_bank (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .init_i      (init),
        .page_base_i (page_base_i),
        .wr_ok_i     (wr_ok),
        .waddr_i     (waddr_i),
        .wdata_i     (wdata_i),
        .regs_o      (regs)
    );

    assign rd_addr[0] = raddr_a_i;
    assign rd_addr[1] = raddr_b_i;

    for (genvar p = 0; p < RF_RD_PORTS; p++) begin : g_rd
        rf_rdport #(
            .XLEN     (XLEN),
            .NUM_REGS (NUM_REGS)
        ) u_rd (
            .regs_i   (regs),
            .raddr_i  (rd_addr[p]),
            .fwd_en_i (wr_ok),
            .waddr_i  (waddr_i),
            .wdata_i  (wdata_i),
            .rdata_o  (rd_data[p])
        );
    end

    assign rdata_a_o = rd_data[0];
    assign rdata_b_o = rd_data[1];

endmodule

// File: rtl/pkt_regfile_checks.sv
module pkt_regfile_checks #(
    parameter int XLEN       = 32,
    parameter int NUM_REGS   = 32,
    parameter int INIT_FIRST = 6,
    parameter int INIT_COUNT = 9,
    localparam int AW        = $clog2(NUM_REGS),
    localparam int PAGE_W    = INIT_COUNT * XLEN
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              sop_i,
    input logic [PAGE_W-1:0] page_base_i,
    input logic              we_i,
    input logic [AW-1:0]     waddr_i,
    input logic [XLEN-1:0]   wdata_i,
    input logic [AW-1:0]     raddr_a_i,
    input logic [XLEN-1:0]   rdata_a_o,
    input logic [AW-1:0]     raddr_b_i,
    input logic [XLEN-1:0]   rdata_b_o,
    input logic              ready_o
);

    logic              accept;
    logic              hit_a;
    logic              in_win_a;
    logic [XLEN-1:0]   seed_a;
    logic [PAGE_W-1:0] page_snap;

    assign accept = we_i && ready_o && !sop_i;
    assign hit_a  = accept && (waddr_i == raddr_a_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            page_snap <= '0;
        end else if (sop_i) begin
            page_snap <= page_base_i;
        end
    end

    always_comb begin
        in_win_a = 1'b0;
        seed_a   = '0;
        for (int k = 0; k < INIT_COUNT; k++) begin
            if (raddr_a_i == AW'(INIT_FIRST + k)) begin
                in_win_a = 1'b1;
                seed_a   = page_snap[k * XLEN +: XLEN];
            end
        end
    end

    p_zero_reg_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (raddr_a_i == '0) |-> (rdata_a_o == '0));

    p_zero_reg_b_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (raddr_b_i == '0) |-> (rdata_b_o == '0));

    p_ready_after_sop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sop_i |=> ready_o);

    p_ready_holds_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ready_o |=> ready_o);

    p_seed_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(sop_i) && !sop_i && in_win_a && !hit_a) |-> (rdata_a_o == seed_a));

    p_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(sop_i) && !sop_i && !in_win_a && !hit_a) |-> (rdata_a_o == '0));

    p_write_lands_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(we_i && ready_o && !sop_i && (waddr_i != '0)) && !sop_i
         && (raddr_a_i == $past(waddr_i)) && !hit_a)
        |-> (rdata_a_o == $past(wdata_i)));

    p_forward_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hit_a && (raddr_a_i != '0)) |-> (rdata_a_o == wdata_i));

endmodule

bind pkt_regfile pkt_regfile_checks #(
    .XLEN       (XLEN),
    .NUM_REGS   (NUM_REGS),
    .INIT_FIRST (INIT_FIRST),
    .INIT_COUNT (INIT_COUNT)
) u_checks (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sop_i       (sop_i),
    .page_base_i (page_base_i),
    .we_i        (we_i),
    .waddr_i     (waddr_i),
    .wdata_i     (wdata_i),
    .raddr_a_i   (raddr_a_i),
    .rdata_a_o   (rdata_a_o),
    .raddr_b_i   (raddr_b_i),
    .rdata_b_o   (rdata_b_o),
    .ready_o     (ready_o)
);

// File: tb/pkt_regfile_tb.sv
`timescale 1ns/1ps
module pkt_regfile_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sop = 1'b0;
    logic [287:0] page = '0;
    logic         we = 1'b0;
    logic [4:0]   waddr = '0;
    logic [31:0]  wdata = '0;
    logic [4:0]   ra = '0;
    logic [4:0]   rb = '0;
    logic [31:0]  rda;
    logic [31:0]  rdb;
    logic         ready;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        logic [4:0]  addr;
        string       req;
    } item_t;

    item_t sb[$];

    logic [31:0] model [32];
    logic        model_ready = 1'b0;

    always #2.5 clk = ~clk;

    pkt_regfile u_dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .sop_i       (sop),
        .page_base_i (page),
        .we_i        (we),
        .waddr_i     (waddr),
        .wdata_i     (wdata),
        .raddr_a_i   (ra),
        .rdata_a_o   (rda),
        .raddr_b_i   (rb),
        .rdata_b_o   (rdb),
        .ready_o     (ready)
    );

    function automatic logic [31:0] expect_rd(input logic [4:0] a, input logic acc,
                                              input logic [4:0] wa, input logic [31:0] wd);
        if (a == 5'd0) return 32'd0;
        if (acc && wa == a) return wd;
        return model[a];
    endfunction

    // Driver: drive one cycle, queue expectations, advance model at the edge.
    task automatic step(input logic s, input logic w, input logic [4:0] wa,
                        input logic [31:0] wd, input logic [4:0] a, input logic [4:0] b,
                        input string req);
        logic acc;
        item_t it;
        @(negedge clk);
        sop = s; we = w; waddr = wa; wdata = wd; ra = a; rb = b;
        acc = w && model_ready && !s;
        it.kind = 0; it.exp = {31'd0, model_ready}; it.addr = '0; it.req = "R3"; sb.push_back(it);
        it.kind = 1; it.exp = expect_rd(a, acc, wa, wd); it.addr = a; it.req = req; sb.push_back(it);
        it.kind = 2; it.exp = expect_rd(b, acc, wa, wd); it.addr = b; it.req = req; sb.push_back(it);
        if (s) begin
            for (int i = 0; i < 32; i++) model[i] = 32'd0;
            for (int k = 0; k < 9; k++) model[6 + k] = page[k * 32 +: 32];
            model_ready = 1'b1;
        end else if (acc && wa != 5'd0) begin
            model[wa] = wd;
        end
    endtask

    // Monitor: compare queued items one nanosecond after the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = sb.pop_front();
                case (it.kind)
                    0:       act = {31'd0, ready};
                    1:       act = rda;
                    default: act = rdb;
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s port=%0d addr=%0d actual=%h expected=%h",
                             it.req, it.kind, it.addr, act, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) model[i] = 32'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, both ports.
        step(0, 0, 0, 0, 5'd5, 5'd31, "R1");
        // R8: write before the first packet is ignored and not forwarded.
        step(0, 1, 5'd5, 32'hDEAD_BEEF, 5'd5, 5'd5, "R8");
        step(0, 0, 0, 0, 5'd5, 5'd6, "R8");

        // First packet: write attempted during the sop cycle is blocked (R8).
        for (int k = 0; k < 9; k++) page[k * 32 +: 32] = 32'h0001_0000 * (k + 1) + k;
        step(1, 1, 5'd7, 32'h5555_AAAA, 5'd7, 5'd7, "R8");
        // R4 / R5: sweep every register after the reload.
        for (int i = 0; i < 32; i++)
            step(0, 0, 0, 0, 5'(i), 5'(31 - i), (i >= 6 && i <= 14) ? "R4" : "R5");

        // R7: same-cycle forward, both ports on one register (R1).
        step(0, 1, 5'd20, 32'h1234_5678, 5'd20, 5'd20, "R7");
        // R6: value held afterwards.
        step(0, 0, 0, 0, 5'd20, 5'd3, "R6");
        step(0, 1, 5'd9, 32'hCAFE_0009, 5'd9, 5'd20, "R7");
        step(0, 0, 0, 0, 5'd9, 5'd20, "R6");
        step(0, 1, 5'd31, 32'hFFFF_0031, 5'd1, 5'd31, "R7");
        step(0, 0, 0, 0, 5'd31, 5'd1, "R6");
        // R2: write to x0 neither stored nor forwarded.
        step(0, 1, 5'd0, 32'hFFFF_FFFF, 5'd0, 5'd0, "R2");
        step(0, 0, 0, 0, 5'd0, 5'd0, "R2");

        // Second packet with a new page image: earlier writes are wiped.
        for (int k = 0; k < 9; k++) page[k * 32 +: 32] = 32'hA000_0000 | (32'h100 * k);
        step(1, 1, 5'd20, 32'h7777_7777, 5'd20, 5'd6, "R8");
        for (int i = 0; i < 32; i++)
            step(0, 0, 0, 0, 5'(i), 5'(i), (i >= 6 && i <= 14) ? "R4" : "R5");
        step(0, 1, 5'd14, 32'h0BAD_F00D, 5'd13, 5'd14, "R7");
        step(0, 0, 0, 0, 5'd14, 5'd13, "R6");

        @(negedge clk);
        #2;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule